// File: doc/BRIEF.md
# Windowed Watchdog Monitor

This block supervises software with a windowed watchdog that has a byte-wide register interface. After software enables it, an internal count advances once per prescaled tick. Software proves that it is alive by writing a two-byte key to the service register while the count lies between a lower and an upper compare bound. A key that is wrong, too slow, too early or too late asserts a monitor output. When the count passes the upper bound, the monitor output also asserts. The monitor output can drive system recovery and can raise an interrupt request.

An external input can also assert the monitor output when it reaches its selected active level. Configuration registers accept one write after reset. Any later attempt to change them is refused and reported as a bus error during that write cycle. The block runs on a single clock. A tick-enable input stands in for the slow counting clock, so no clock-domain crossing is needed.

Top module: `xwd_monitor`

## Requirements
- R1: After reset, offset 0 reads 0x00, offset 2 reads 0x00, offset 3 reads 0xFF and offset 5 reads 0x00. `mon_out`, `irq` and `bus_err` are all low.
- R2: The byte registers sit at these offsets: control 0, service 1, window low 2, window high 3, divider 5. Reads of offsets 1, 4, 6 and 7 return zero. Writes to offsets 4, 6 and 7 change nothing and raise no error. Control bits 7:4 always read as zero.
- R3: Window low, window high and divider take only their first write after reset. A later write leaves the stored value unchanged and drives `bus_err` high during that write cycle. A first write never raises `bus_err`.
- R4: Control bit 0 is run, bit 1 is input polarity and bit 2 is input enable. These three bits are fixed by the first control write. A later control write that would change any of them is refused for those bits and raises `bus_err`. Bit 3 (interrupt enable) takes every write.
- R5: While running, the count rises by one per prescaled tick and saturates at 0xFF. `mon_out` asserts on the clock edge after the count first exceeds window high. With window high at 0xFF, the output never expires.
- R6: With divider value P and `tick_en` held high, the count advances once every P+1 clocks. The first advance comes P+1 clocks after the enabling control write.
- R7: A service write of 0xB4 followed by a service write of 0x2C is a valid key. If the count is within [window low, window high] when the 0x2C is written, the count is cleared on that clock edge.
- R8: A valid key written while the count is below window low asserts `mon_out` on the clock edge of the 0x2C write.
- R9: A first byte other than 0xB4, or a second byte other than 0x2C, asserts `mon_out` on that write's edge. If the second byte is not written within GAP_MAX clocks of the first, `mon_out` also asserts. A second byte exactly GAP_MAX clocks after the first is still accepted.
- R10: When input enable is set and `ext_in` equals the polarity bit (0 means active low), `mon_out` asserts on the next clock edge. When input enable is clear, `ext_in` has no effect.
- R11: Once asserted, `mon_out` stays high until reset or until a valid in-window key arrives while the external input is inactive. A valid key made while the input is active leaves it high.
- R12: `irq` is high exactly when interrupt enable is set and `mon_out` is high. Writing 0 to interrupt enable removes the request.
- R13: If the first control write leaves run clear, the block never runs until reset. The count stays idle, service writes are ignored and `mon_out` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus and counting logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable marking each slow source tick |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for the selected offset |
| bus_err | output | 1 | High during a write refused by write-once protection |
| ext_in | input | 1 | External fault input |
| mon_out | output | 1 | Monitor output, high when a fault is flagged |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the embedded properties check these invariants: locked configuration bytes hold their value, the count only steps by one or returns to zero, and the divider phase stays within its bound. They also check that the key gap counter never passes GAP_MAX, that an idle block never flags, that an expired count or an active input flags on the next edge, and that a flagged output holds until a good refresh. Only the directed scenarios can show the exact clock on which a prescaled expiry lands and the gap boundary of exactly GAP_MAX versus one clock more. The same is true of the difference between a refresh made with the input active and one made with it inactive, and of the error reporting on refused writes.

// File: rtl/xwd_pkg.sv
package xwd_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_SERV = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_WLO  = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_WHI  = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_DIV  = 3'd5;

   localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'hB4;
   localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h2C;

   // packed so that bit 0 is run and bit 3 is interrupt enable
   typedef struct packed {
      logic irq_en;
      logic pin_en;
      logic pin_pol;
      logic run;
   } ctrl_t;

   typedef enum logic {KS_IDLE, KS_ARMED} key_st_t;
endpackage

// File: rtl/xwd_regs.sv
module xwd_regs
   import xwd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              err,
   output ctrl_t             ctrl,
   output logic [BYTE_W-1:0] win_lo,
   output logic [BYTE_W-1:0] win_hi,
   output logic [BYTE_W-1:0] div,
   output logic              run_set,
   output logic              serv_wr
);
   // write-once byte registers: index 0 window low, 1 window high, 2 divider
   localparam int NB = 3;
   localparam logic [NB-1:0][ADDR_W-1:0] B_OFS = {OFS_DIV, OFS_WHI, OFS_WLO};
   localparam logic [NB-1:0][BYTE_W-1:0] B_RST = {8'h00, 8'hFF, 8'h00};

   logic [NB-1:0][BYTE_W-1:0] b_q;
   logic [NB-1:0]             b_done;
   logic [NB-1:0]             b_hit;
   logic [NB-1:0]             b_err;

   ctrl_t ctrl_q;
   ctrl_t ctrl_w;
   logic  ctrl_done;
   logic  hit_ctrl;
   logic  ctrl_diff;

   assign hit_ctrl  = wr && (addr == OFS_CTRL);
   assign serv_wr   = wr && (addr == OFS_SERV);
   assign ctrl_w    = ctrl_t'(wdata[3:0]);
   assign ctrl_diff = (ctrl_w.run != ctrl_q.run) || (ctrl_w.pin_pol != ctrl_q.pin_pol)
                    || (ctrl_w.pin_en != ctrl_q.pin_en);
   assign run_set   = hit_ctrl && !ctrl_done && ctrl_w.run;

   for (genvar i = 0; i < NB; i++) begin : g_once
      assign b_hit[i] = wr && (addr == B_OFS[i]);
      assign b_err[i] = b_hit[i] && b_done[i];

      a_r3_once_hold: assert property (@(posedge clk) disable iff (!rst_n)
         b_done[i] |=> $stable(b_q[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q    <= B_RST;
         b_done <= '0;
      end else begin
         for (int i = 0; i < NB; i++) begin
            if (b_hit[i] && !b_done[i]) begin
               b_q[i]    <= wdata;
               b_done[i] <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         ctrl_done <= 1'b0;
      end else if (hit_ctrl) begin
         ctrl_q.irq_en <= ctrl_w.irq_en;
         if (!ctrl_done) begin
            ctrl_q.run     <= ctrl_w.run;
            ctrl_q.pin_pol <= ctrl_w.pin_pol;
            ctrl_q.pin_en  <= ctrl_w.pin_en;
            ctrl_done      <= 1'b1;
         end
      end
   end

   assign err = (hit_ctrl && ctrl_done && ctrl_diff) || (|b_err);

   always_comb begin
      unique case (addr)
         OFS_CTRL: rdata = {4'b0000, ctrl_q};
         OFS_WLO:  rdata = b_q[0];
         OFS_WHI:  rdata = b_q[1];
         OFS_DIV:  rdata = b_q[2];
         default:  rdata = '0;
      endcase
   end

   assign ctrl   = ctrl_q;
   assign win_lo = b_q[0];
   assign win_hi = b_q[1];
   assign div    = b_q[2];

   a_r4_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_done |=> (ctrl_q.run == $past(ctrl_q.run)) && (ctrl_q.pin_en == $past(ctrl_q.pin_en))
                    && (ctrl_q.pin_pol == $past(ctrl_q.pin_pol)));
endmodule

// File: rtl/xwd_prescale.sv
module xwd_prescale
   import xwd_pkg::*;
#(
   parameter bit USE_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick_en,
   input  logic [BYTE_W-1:0] div,
   output logic              ptick
);
   if (USE_DIV) begin : g_div
      logic [BYTE_W-1:0] ph_q;
      logic              wrap;

      assign wrap  = (ph_q >= div);
      assign ptick = run && tick_en && wrap;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ph_q <= '0;
         else if (!run)    ph_q <= '0;
         else if (tick_en) ph_q <= wrap ? '0 : ph_q + 1'b1;
      end

      a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
         run && $past(run) && $stable(div) |-> (ph_q <= div));
   end else begin : g_pass
      logic unused_div;
      assign unused_div = |div;
      assign ptick = run && tick_en;
   end
endmodule

// File: rtl/xwd_keyseq.sv
module xwd_keyseq
   import xwd_pkg::*;
#(
   parameter int GAP_MAX = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              serv_wr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              key_ok,
   output logic              key_bad
);
   localparam int GW = $clog2(GAP_MAX + 1);

   key_st_t       st_q, st_d;
   logic [GW-1:0] gap_q, gap_d;

   always_comb begin
      st_d    = st_q;
      gap_d   = gap_q;
      key_ok  = 1'b0;
      key_bad = 1'b0;
      if (!run) begin
         st_d  = KS_IDLE;
         gap_d = '0;
      end else begin
         unique case (st_q)
            KS_IDLE: begin
               if (serv_wr) begin
                  if (wdata == KEY_FIRST) begin
                     st_d  = KS_ARMED;
                     gap_d = GW'(1);
                  end else begin
                     key_bad = 1'b1;
                  end
               end
            end
            KS_ARMED: begin
               if (serv_wr) begin
                  st_d  = KS_IDLE;
                  gap_d = '0;
                  if (wdata == KEY_SECOND) key_ok  = 1'b1;
                  else                     key_bad = 1'b1;
               end else if (gap_q >= GW'(GAP_MAX)) begin
                  st_d    = KS_IDLE;
                  gap_d   = '0;
                  key_bad = 1'b1;
               end else begin
                  gap_d = gap_q + GW'(1);
               end
            end
            default: st_d = KS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= KS_IDLE;
         gap_q <= '0;
      end else begin
         st_q  <= st_d;
         gap_q <= gap_d;
      end
   end

   a_r9_gap_limit: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= GW'(GAP_MAX));
   a_r9_armed_timing: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == KS_ARMED) |-> (gap_q != '0));
endmodule

// File: rtl/xwd_core.sv
module xwd_core
   import xwd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              run_set,
   input  logic              ptick,
   input  logic              key_ok,
   input  logic              key_bad,
   input  logic              pin_act,
   input  logic [BYTE_W-1:0] win_lo,
   input  logic [BYTE_W-1:0] win_hi,
   output logic              mon
);
   logic [BYTE_W-1:0] cnt_q;
   logic              mon_q;
   logic              in_win;
   logic              good;
   logic              fault;

   assign in_win = (cnt_q >= win_lo) && (cnt_q <= win_hi);
   assign good   = key_ok && in_win;
   assign fault  = (key_ok && !in_win) || key_bad || pin_act || (cnt_q > win_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mon_q <= 1'b0;
      end else if (run_set) begin
         cnt_q <= '0;
         mon_q <= 1'b0;
      end else if (run) begin
         if (good)                       cnt_q <= '0;
         else if (ptick && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
         if (fault)      mon_q <= 1'b1;
         else if (good)  mon_q <= 1'b0;
      end
   end

   assign mon = mon_q;

   a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));
   a_r5_expire: assert property (@(posedge clk) disable iff (!rst_n)
      run && (cnt_q > win_hi) |=> mon_q);
   a_r11_mon_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mon_q && !key_ok |=> mon_q);
   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mon_q);
endmodule

// File: rtl/xwd_monitor.sv
module xwd_monitor
   import xwd_pkg::*;
#(
   parameter int GAP_MAX = 15,
   parameter bit USE_DIV = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       bus_wr,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       bus_err,
   input  logic       ext_in,
   output logic       mon_out,
   output logic       irq
);
   if (GAP_MAX < 1 || GAP_MAX > 255) begin : g_bad_gap
      $error("xwd_monitor: GAP_MAX must lie in 1..255");
   end

   ctrl_t             ctrl;
   logic [BYTE_W-1:0] win_lo, win_hi, div;
   logic              run_set, serv_wr, ptick, key_ok, key_bad, pin_act;

   xwd_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .err     (bus_err),
      .ctrl    (ctrl),
      .win_lo  (win_lo),
      .win_hi  (win_hi),
      .div     (div),
      .run_set (run_set),
      .serv_wr (serv_wr)
   );

   xwd_prescale #(.USE_DIV(USE_DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl.run),
      .tick_en (tick_en),
      .div     (div),
      .ptick   (ptick)
   );

   xwd_keyseq #(.GAP_MAX(GAP_MAX)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl.run),
      .serv_wr (serv_wr),
      .wdata   (bus_wdata),
      .key_ok  (key_ok),
      .key_bad (key_bad)
   );

   assign pin_act = ctrl.run && ctrl.pin_en && (ext_in == ctrl.pin_pol);

   xwd_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl.run),
      .run_set (run_set),
      .ptick   (ptick),
      .key_ok  (key_ok),
      .key_bad (key_bad),
      .pin_act (pin_act),
      .win_lo  (win_lo),
      .win_hi  (win_hi),
      .mon     (mon_out)
   );

   assign irq = ctrl.irq_en && mon_out;

   a_r10_pin_trip: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.run && ctrl.pin_en && (ext_in == ctrl.pin_pol) |=> mon_out);
endmodule

// File: tb/sim_xwd_monitor.sv
module sim_xwd_monitor;
   localparam int GAP = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_err;
   logic       ext_in = 1'b1;
   logic       mon_out;
   logic       irq;

   int checks = 0;
   int errors = 0;
   logic last_err;

   always #4 clk = ~clk;

   xwd_monitor #(.GAP_MAX(GAP)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .ext_in(ext_in), .mon_out(mon_out), .irq(irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_wr = 1'b0; ext_in = 1'b1; tick_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive at a falling edge, capture the error response, return just after the rising edge
   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      #1 last_err = bus_err;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic setup(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] dv, input logic [7:0] c);
      bus_write(3'd5, dv);
      bus_write(3'd2, lo);
      bus_write(3'd3, hi);
      bus_write(3'd0, c);
   endtask

   task automatic refresh();
      bus_write(3'd1, 8'hB4);
      bus_write(3'd1, 8'h2C);
   endtask

   task automatic t_reset_state();
      logic [7:0] v;
      do_reset();
      bus_read(3'd0, v); chk("R1", "ctrl reset", v, 8'h00);
      bus_read(3'd2, v); chk("R1", "window low reset", v, 8'h00);
      bus_read(3'd3, v); chk("R1", "window high reset", v, 8'hFF);
      bus_read(3'd5, v); chk("R1", "divider reset", v, 8'h00);
      chk("R1", "outputs after reset", {bus_err, irq, mon_out}, 3'b000);
   endtask

   task automatic t_decode_and_idle();
      logic [7:0] v;
      do_reset();
      bus_write(3'd4, 8'h5A); chk("R2", "reserved write error", last_err, 1'b0);
      bus_read(3'd4, v);      chk("R2", "reserved reads zero", v, 8'h00);
      bus_write(3'd6, 8'hFF);
      bus_read(3'd6, v);      chk("R2", "offset 6 reads zero", v, 8'h00);
      bus_read(3'd1, v);      chk("R2", "service reads zero", v, 8'h00);
      bus_write(3'd0, 8'hF0); chk("R2", "ctrl first write error", last_err, 1'b0);
      bus_read(3'd0, v);      chk("R2", "ctrl upper bits zero", v, 8'h00);
      bus_write(3'd0, 8'h01); chk("R13", "late enable refused", last_err, 1'b1);
      bus_read(3'd0, v);      chk("R13", "enable stays clear", v, 8'h00);
      bus_write(3'd1, 8'h77);
      chk("R13", "bad key ignored when idle", mon_out, 1'b0);
      repeat (300) @(posedge clk);
      #1 chk("R13", "no expiry when idle", mon_out, 1'b0);
   endtask

   task automatic t_write_once();
      logic [7:0] v;
      do_reset();
      bus_write(3'd2, 8'h05); chk("R3", "low first write error", last_err, 1'b0);
      bus_write(3'd2, 8'h07); chk("R3", "low second write error", last_err, 1'b1);
      bus_read(3'd2, v);      chk("R3", "low keeps first", v, 8'h05);
      bus_write(3'd3, 8'h20); chk("R3", "high first write error", last_err, 1'b0);
      bus_write(3'd3, 8'h30); chk("R3", "high second write error", last_err, 1'b1);
      bus_read(3'd3, v);      chk("R3", "high keeps first", v, 8'h20);
      bus_write(3'd5, 8'h02);
      bus_write(3'd5, 8'h04); chk("R3", "divider second write error", last_err, 1'b1);
      bus_read(3'd5, v);      chk("R3", "divider keeps first", v, 8'h02);
   endtask

   task automatic t_ctrl_lock();
      logic [7:0] v;
      do_reset();
      bus_write(3'd0, 8'h01); chk("R4", "ctrl first write error", last_err, 1'b0);
      bus_write(3'd0, 8'h07); chk("R4", "ctrl change error", last_err, 1'b1);
      bus_read(3'd0, v);      chk("R4", "locked bits kept", v, 8'h01);
      bus_write(3'd0, 8'h09); chk("R4", "irq enable write error", last_err, 1'b0);
      bus_read(3'd0, v);      chk("R4", "irq enable taken", v, 8'h09);
   endtask

   task automatic t_expiry();
      do_reset();
      setup(8'h00, 8'h03, 8'h00, 8'h01);
      repeat (4) @(posedge clk);
      #1 chk("R5", "not expired at edge 4", mon_out, 1'b0);
      @(posedge clk);
      #1 chk("R5", "expired at edge 5", mon_out, 1'b1);
      do_reset();
      setup(8'h00, 8'hFF, 8'h00, 8'h01);
      repeat (600) @(posedge clk);
      #1 chk("R5", "high 0xFF never expires", mon_out, 1'b0);
   endtask

   task automatic t_prescale();
      do_reset();
      setup(8'h00, 8'h03, 8'h03, 8'h01);
      repeat (16) @(posedge clk);
      #1 chk("R6", "div 3 not expired at edge 16", mon_out, 1'b0);
      @(posedge clk);
      #1 chk("R6", "div 3 expired at edge 17", mon_out, 1'b1);
   endtask

   task automatic t_valid_refresh();
      do_reset();
      setup(8'h02, 8'h0A, 8'h00, 8'h01);
      repeat (3) @(posedge clk);
      refresh();
      chk("R7", "valid key no flag", mon_out, 1'b0);
      repeat (9) @(posedge clk);
      #1 chk("R7", "count was cleared", mon_out, 1'b0);
      repeat (3) @(posedge clk);
      #1 chk("R7", "expiry after restart", mon_out, 1'b1);
   endtask

   task automatic t_early_refresh_irq();
      do_reset();
      setup(8'h08, 8'h14, 8'h00, 8'h01);
      bus_write(3'd1, 8'hB4);
      chk("R8", "first byte no flag", mon_out, 1'b0);
      bus_write(3'd1, 8'h2C);
      chk("R8", "early key flags", mon_out, 1'b1);
      chk("R12", "irq masked", irq, 1'b0);
      bus_write(3'd0, 8'h09);
      chk("R12", "irq raised", irq, 1'b1);
      bus_write(3'd0, 8'h01);
      chk("R12", "irq removed", irq, 1'b0);
      chk("R11", "flag held after irq clear", mon_out, 1'b1);
   endtask

   task automatic t_illegal();
      do_reset();
      setup(8'h00, 8'h80, 8'h00, 8'h01);
      bus_write(3'd1, 8'h2C);
      chk("R9", "wrong first byte", mon_out, 1'b1);
      do_reset();
      setup(8'h00, 8'h80, 8'h00, 8'h01);
      bus_write(3'd1, 8'hB4);
      bus_write(3'd1, 8'h55);
      chk("R9", "wrong second byte", mon_out, 1'b1);
      do_reset();
      setup(8'h00, 8'h80, 8'h00, 8'h01);
      bus_write(3'd1, 8'hB4);
      repeat (GAP - 1) @(posedge clk);
      bus_write(3'd1, 8'h2C);
      chk("R9", "gap equal to limit accepted", mon_out, 1'b0);
      do_reset();
      setup(8'h00, 8'h80, 8'h00, 8'h01);
      bus_write(3'd1, 8'hB4);
      repeat (GAP) @(posedge clk);
      bus_write(3'd1, 8'h2C);
      chk("R9", "gap over limit flags", mon_out, 1'b1);
   endtask

   task automatic t_pin();
      do_reset();
      setup(8'h00, 8'h80, 8'h00, 8'h05);
      repeat (4) @(posedge clk);
      #1 chk("R10", "inactive high level", mon_out, 1'b0);
      @(negedge clk) ext_in = 1'b0;
      @(posedge clk);
      #1 chk("R10", "active low trips", mon_out, 1'b1);
      refresh();
      chk("R11", "refresh with input active keeps flag", mon_out, 1'b1);
      @(negedge clk) ext_in = 1'b1;
      repeat (3) @(posedge clk);
      #1 chk("R11", "flag sticky after release", mon_out, 1'b1);
      refresh();
      chk("R11", "refresh with input inactive clears", mon_out, 1'b0);
      do_reset();
      ext_in = 1'b0;
      setup(8'h00, 8'h80, 8'h00, 8'h07);
      repeat (3) @(posedge clk);
      #1 chk("R10", "active-high idle at 0", mon_out, 1'b0);
      @(negedge clk) ext_in = 1'b1;
      @(posedge clk);
      #1 chk("R10", "active-high trips", mon_out, 1'b1);
      do_reset();
      ext_in = 1'b0;
      setup(8'h00, 8'h80, 8'h00, 8'h01);
      repeat (5) @(posedge clk);
      #1 chk("R10", "input disabled ignored", mon_out, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset_state();
      t_decode_and_idle();
      t_write_once();
      t_ctrl_lock();
      t_expiry();
      t_prescale();
      t_valid_refresh();
      t_early_refresh_irq();
      t_illegal();
      t_pin();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule